// File: doc/BRIEF.md
# Framed Serial Command Word Receiver

This block takes 16-bit command words from a three-wire serial link: an active-low frame line, a serial clock and a data line. All three lines are asynchronous to the block's fast system clock. Each line passes through its own two-stage synchroniser. Serial clock edges are found by comparing successive synchronised samples, so the system clock must run at least eight times faster than the serial clock. The serial clock runs at up to 5 MHz, which is a 200 ns period at about 50 percent duty.

While the frame line is low, the block takes one data bit on each rising edge of the serial clock. The first bit received becomes bit 0 of the word and the sixteenth becomes bit 15. The word is not handed on when the sixteenth bit arrives. It is handed on when the frame line goes high again, and only if exactly sixteen bits were taken. On a good frame the block raises a one-cycle strobe and updates the word output. A frame with any other bit count is dropped without a strobe. The word output then keeps the last good word until the next good frame.

Top module: `serial_word_rx`

## Requirements
- R1: After reset, word_o is 16'h0000 and word_valid_o is 0.
- R2: Bits are assembled least significant first: the n-th rising serial clock edge of a frame (counting from 0) sets word_o[n] to the data line value at that edge.
- R3: A frame of exactly 16 bits is committed when frame_n_i rises. word_valid_o is high for exactly one system clock cycle, and that cycle starts on the third rising system clock edge after the rise of frame_n_i is presented.
- R4: When frame_n_i rises after fewer than 16 or more than 16 bits, word_valid_o stays low and word_o keeps its previous value.
- R5: Rising serial clock edges while frame_n_i is high have no effect. They raise no strobe, leave word_o unchanged and add no bit to the next frame.
- R6: A serial clock that is already high when frame_n_i falls is not counted as an edge. Only later low-to-high transitions are counted.
- R7: The bit count and the partial word clear at each falling edge of frame_n_i, so bits from a rejected frame never reach a later word.
- R8: word_o changes only in the cycle in which word_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n_i | input | 1 | Active-low frame line (asynchronous) |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial data, sampled on rising sclk_i |
| word_o | output | 16 | Last word accepted from a good frame |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
A change on any serial line reaches the decision logic after two synchroniser stages and one edge register. The commit strobe is therefore due in the third system cycle after the release of the frame line is driven. The bench drives every input on the falling system clock edge. After each release it samples the outputs on the six following falling edges. A good frame must show one strobe, at exactly the third of those samples, carrying the expected word. A bad frame must show no strobe and an unchanged word. A free-running strobe counter also catches any strobe raised during stray clocking outside a frame.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

    // Events decoded from the synchronised serial lines, one system cycle wide
    typedef struct packed {
        logic frm_active;   // frame line currently low
        logic frm_fall;     // frame line just went low
        logic frm_rise;     // frame line just went high
        logic clk_rise;     // serial clock just went high
        logic data;         // synchronised data level
    } line_evt_t;

    localparam int unsigned LINE_FRAME = 0;
    localparam int unsigned LINE_SCLK  = 1;
    localparam int unsigned LINE_DATA  = 2;
    localparam int unsigned NUM_LINES  = 3;

endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
    parameter int unsigned LINES  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [LINES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/ser_rx_edge.sv
module ser_rx_edge
    import ser_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] sync_i,
    output line_evt_t            evt_o
);

    typedef struct packed {
        logic frame;
        logic sclk;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.frame = sync_i[LINE_FRAME];
        prev_d.sclk  = sync_i[LINE_SCLK];

        evt_o.frm_active = ~sync_i[LINE_FRAME];
        evt_o.frm_fall   = prev_q.frame & ~sync_i[LINE_FRAME];
        evt_o.frm_rise   = ~prev_q.frame & sync_i[LINE_FRAME];
        evt_o.clk_rise   = ~prev_q.sclk & sync_i[LINE_SCLK];
        evt_o.data       = sync_i[LINE_DATA];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{frame: 1'b1, sclk: 1'b0};
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/ser_rx_assembler.sv
module ser_rx_assembler
    import ser_rx_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_evt_t         evt_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);

    localparam int unsigned CNT_MAX = WORD_W + 1;           // saturating "too many"
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  count;
        logic [WORD_W-1:0] word;
        logic              valid;
    } asm_state_t;

    asm_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;

        if (evt_i.frm_fall) begin
            st_d.shift = '0;
            st_d.count = '0;
        end else if (evt_i.frm_active && evt_i.clk_rise) begin
            // newest bit enters at the top; after WORD_W shifts the first bit sits at bit 0
            st_d.shift = {evt_i.data, st_q.shift[WORD_W-1:1]};
            if (st_q.count != CNT_W'(CNT_MAX)) begin
                st_d.count = st_q.count + 1'b1;
            end
        end

        if (evt_i.frm_rise && (st_q.count == CNT_W'(WORD_W))) begin
            st_d.word  = st_q.shift;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
    import ser_rx_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o
);

    localparam logic [NUM_LINES-1:0] LINE_RST = NUM_LINES'(1) << LINE_FRAME;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] sync_lines;
    line_evt_t            evt;

    always_comb begin
        raw_lines             = '0;
        raw_lines[LINE_FRAME] = frame_n_i;
        raw_lines[LINE_SCLK]  = sclk_i;
        raw_lines[LINE_DATA]  = sdata_i;
    end

    ser_rx_sync #(
        .LINES  (NUM_LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINE_RST)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_lines),
        .sync_o (sync_lines)
    );

    ser_rx_edge i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sync_i(sync_lines),
        .evt_o (evt)
    );

    ser_rx_assembler #(
        .WORD_W(WORD_W)
    ) i_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .word_o (word_o),
        .valid_o(word_valid_o)
    );

endmodule

// File: rtl/serial_word_rx_chk.sv
module serial_word_rx_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n_i,
    input logic [WORD_W-1:0] word_o,
    input logic              word_valid_o
);

    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o) else $error("strobe longer than one cycle"); // R3

    AST_COMMIT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> ($past(frame_n_i, 3) && !$past(frame_n_i, 4)))
        else $error("strobe not three cycles after frame release"); // R3

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(word_o)) else $error("word changed without strobe"); // R8

    AST_NO_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(frame_n_i, 3)) else $error("strobe while frame active"); // R5

endmodule

bind serial_word_rx serial_word_rx_chk #(.WORD_W(WORD_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n_i   (frame_n_i),
    .word_o      (word_o),
    .word_valid_o(word_valid_o)
);

// File: tb/test_serial_word_rx.sv
module test_serial_word_rx;

    localparam int unsigned W    = 16;
    localparam int unsigned HALF = 6;     // serial half period in system cycles

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdata = 1'b0;
    logic [W-1:0] word;
    logic         valid;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    bit done = 1'b0;
    logic [W-1:0] model_word = '0;

    always #5 clk = ~clk;

    serial_word_rx i_serial_word_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_n_i   (frame_n),
        .sclk_i      (sclk),
        .sdata_i     (sdata),
        .word_o      (word),
        .word_valid_o(valid)
    );

    always @(negedge clk) if (valid) strobes++;

    function automatic logic [W-1:0] exp_word(input logic [31:0] bits, input int n,
                                              input logic [W-1:0] prev);
        return (n == W) ? bits[W-1:0] : prev;
    endfunction

    function automatic int exp_hits(input int n);
        return (n == W) ? 1 : 0;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic stray_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sdata = i[0];
            tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
        end
        tick(HALF);
    endtask

    task automatic send_frame(input logic [31:0] bits, input int n, input bit start_high,
                              input string req);
        int hit_at;
        int hits;
        int base;
        logic [W-1:0] at_hit;
        logic [W-1:0] expw;
        if (start_high) begin
            sclk = 1'b1; tick(HALF);
        end
        frame_n = 1'b0;
        tick(HALF);
        if (start_high) begin
            sclk = 1'b0; tick(HALF);
        end
        for (int i = 0; i < n; i++) begin
            sdata = bits[i];
            tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
        end
        tick(HALF);
        base = strobes;
        frame_n = 1'b1;
        hits = 0; hit_at = 0; at_hit = word;
        for (int k = 1; k <= 6; k++) begin
            tick(1);
            if (valid) begin
                hits++; hit_at = k; at_hit = word;
            end
        end
        expw = exp_word(bits, n, model_word);
        check(hits == exp_hits(n), {req, " strobe count"}, hits, exp_hits(n));
        if (exp_hits(n) == 1) begin
            check(hit_at == 3, "R3 strobe cycle", hit_at, 3);
            check(at_hit == expw, {req, " word at strobe"}, at_hit, expw);
        end
        check(word == expw, {req, " word after frame"}, word, expw);
        check(strobes - base == hits, "R5 stray strobe", strobes - base, hits);
        model_word = expw;
        tick(HALF);
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        tick(3);
        check(word == '0, "R1 word reset", word, 0);
        check(valid == 1'b0, "R1 valid reset", valid, 0);
        rst_n = 1'b1;
        tick(4);
        check(strobes == 0, "R1 no strobe", strobes, 0);

        // R2: walking bit patterns verify LSB-first placement
        send_frame(32'h0000_0001, 16, 1'b0, "R2");
        send_frame(32'h0000_8000, 16, 1'b0, "R2");
        send_frame(32'h0000_A5C3, 16, 1'b0, "R2");
        // R4: short and long frames dropped
        send_frame(32'h0000_FFFF, 15, 1'b0, "R4");
        send_frame(32'h0001_1234, 17, 1'b0, "R4");
        send_frame(32'h0000_0000, 0, 1'b0, "R4");
        // R5: stray clocking outside a frame changes nothing
        base = strobes;
        stray_pulses(5);
        check(strobes == base, "R5 no strobe on stray", strobes - base, 0);
        check(word == model_word, "R5 word kept", word, model_word);
        send_frame(32'h0000_3C96, 16, 1'b0, "R5");
        // R6: clock high as frame opens is not an edge
        send_frame(32'h0000_7E01, 16, 1'b1, "R6");
        // R7: partial frame then a full one
        send_frame(32'h0000_001F, 5, 1'b0, "R7");
        send_frame(32'h0000_8421, 16, 1'b0, "R7");

        for (int t = 0; t < 30; t++) begin
            logic [31:0] d;
            int n;
            int sel;
            d = $urandom();
            sel = int'($urandom_range(0, 7));
            if (sel == 0) n = int'($urandom_range(1, 15));
            else if (sel == 1) n = int'($urandom_range(17, 20));
            else n = 16;
            send_frame(d, n, $urandom_range(0, 3) == 0, (n == 16) ? "R2" : "R4");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule